// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a slave on a two-wire serial bus (SCL clock, SDA open-drain data) that holds a small bank of eight-bit configuration registers. It only understands whole-bank block transfers. There is no register pointer. A write always fills the bank from register 0 upward, after two leading bytes that are acknowledged and discarded. A read always returns a byte count first and then the bank from register 0 upward.

Both bus lines are oversampled on the system clock through a two-flop synchroniser. The block drives SDA only through an output enable, which pulls the line low. The register bank appears on a parallel output bus. Selected bits of that bus are read-only: they show the live level of the status inputs, and bus writes leave them untouched.

Top module: `cfg_block_slave`

## Requirements
- R1: The 7-bit device address is 0x69. Address byte D2h (R/W bit 0) selects a write and D3h (R/W bit 1) selects a read, and both are acknowledged. Any other address byte is not acknowledged, and the slave stays off the bus until the next start.
- R2: In a write, the two bytes after the address byte are acknowledged and discarded, and no register changes because of them.
- R3: In a write, the third and later data bytes go into register 0, 1, 2 and so on in ascending order. Register k sits at regs_o[8k+7:8k].
- R4: A stop after any complete byte ends the write. Registers the write did not reach keep their previous contents.
- R5: A read returns 8'd7 first and then registers 0 through 6, each byte MSB first. The slave changes SDA only while SCL is low.
- R6: After reset, the bank holds 08h, 47h, 7Fh, C7h, 3Fh, 00h, 00h for registers 0 to 6.
- R7: Bit 4 of register 0 and bit 7 of register 1 are read-only. On regs_o and in read data they equal the same bits of status_i, and bus writes to them have no effect.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing more until a stop or a repeated start.
- R9: Write data bytes beyond register 6 are acknowledged and discarded.
- R10: The slave pulls SDA low during the ninth clock of every byte it accepts. It keeps SDA released while the host sends address or data bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | When high, pull SDA low |
| status_i | input | 56 | Levels shown in the read-only bit positions |
| regs_o | output | 56 | Register bank, register k at bits 8k+7:8k |

## Verification
The bank is written in three ways: a full write with two extra trailing bytes, a short write stopped after three bytes, and a read that ends with a host NACK. Comparing the results tells in-order loading apart from an off-by-one in the dummy-byte skip. It also separates clipping at the last register from wrap-around, and a stop that preserves registers from one that clears them. A foreign address and changes on the status inputs then separate correct address decoding and read-only masking from writes that leak through.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_WAIT
    } bus_state_e;
endpackage

// File: rtl/cbs_bus_sync.sv
module cbs_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic [STAGES:0] scl;
        logic [STAGES:0] sda;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.scl = {s_q.scl[STAGES-1:0], scl_i};
        s_d.sda = {s_q.sda[STAGES-1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    logic scl_now, scl_old, sda_now, sda_old;
    assign scl_now    = s_q.scl[STAGES-1];
    assign scl_old    = s_q.scl[STAGES];
    assign sda_now    = s_q.sda[STAGES-1];
    assign sda_old    = s_q.sda[STAGES];
    assign sda_o      = sda_now;
    assign scl_rise_o = scl_now & ~scl_old;
    assign scl_fall_o = ~scl_now & scl_old;
    assign start_o    = scl_now & scl_old & sda_old & ~sda_now;
    assign stop_o     = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/cbs_reg_bank.sv
module cbs_reg_bank #(
    parameter int NREGS = 7,
    parameter int AW    = 4,
    parameter logic [NREGS*8-1:0] RST_VALS = 56'h00003FC77F4708,
    parameter logic [NREGS*8-1:0] RO_MASK  = 56'h00000000008010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [AW-1:0]      waddr_i,
    input  logic [7:0]         wdata_i,
    input  logic [NREGS*8-1:0] status_i,
    output logic [NREGS*8-1:0] regs_o
);
    typedef struct packed {
        logic [NREGS*8-1:0] bank;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        for (int k = 0; k < NREGS; k++) begin
            if (we_i && (int'(waddr_i) == k)) begin
                b_d.bank[k*8 +: 8] = (wdata_i & ~RO_MASK[k*8 +: 8])
                                   | (b_q.bank[k*8 +: 8] & RO_MASK[k*8 +: 8]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q.bank <= RST_VALS;
        else        b_q      <= b_d;
    end

    assign regs_o = (b_q.bank & ~RO_MASK) | (status_i & RO_MASK);

    // Without a write strobe the bank must hold every bit.
    assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(b_q.bank));
    // The read-only positions of the stored bank never change.
    assert_ro_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> ((b_q.bank & RO_MASK) == ($past(b_q.bank) & RO_MASK)));
endmodule

// File: rtl/cfg_block_slave.sv
module cfg_block_slave #(
    parameter int NREGS       = 7,
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter logic [NREGS*8-1:0] RST_VALS = 56'h00003FC77F4708,
    parameter logic [NREGS*8-1:0] RO_MASK  = 56'h00000000008010
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_oe_o,
    input  logic [NREGS*8-1:0] status_i,
    output logic [NREGS*8-1:0] regs_o
);
    import cbs_pkg::*;

    localparam int CNT_W = $clog2(NREGS + 3);
    localparam logic [CNT_W-1:0] WLIM = CNT_W'(NREGS + 2);
    localparam logic [CNT_W-1:0] RLIM = CNT_W'(NREGS + 1);

    logic sda_s, scl_rise, scl_fall, bus_start, bus_stop;

    cbs_bus_sync #(.STAGES(2)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_o      (sda_s),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (bus_start),
        .stop_o     (bus_stop)
    );

    typedef struct packed {
        bus_state_e       state;
        logic [3:0]       bitcnt;
        logic [7:0]       shift;
        logic             rw;
        logic             acked;
        logic             oe;
        logic [CNT_W-1:0] wcnt;
        logic [CNT_W-1:0] ridx;
    } ctl_t;

    ctl_t c_d, c_q;
    logic             wr_en;
    logic [CNT_W-1:0] wr_addr;
    logic [7:0]       tx_byte;
    logic [7:0]       reg_arr [NREGS];

    for (genvar g = 0; g < NREGS; g++) begin : g_unpack
        assign reg_arr[g] = regs_o[g*8 +: 8];
    end

    // Byte to send for the current read index: count, registers, then filler.
    always_comb begin
        tx_byte = 8'hFF;
        if (c_q.ridx == '0) tx_byte = 8'(NREGS);
        for (int k = 0; k < NREGS; k++) begin
            if (int'(c_q.ridx) == k + 1) tx_byte = reg_arr[k];
        end
    end

    always_comb begin
        c_d     = c_q;
        wr_en   = 1'b0;
        wr_addr = '0;
        if (bus_start) begin
            c_d.state  = ST_ADDR;
            c_d.bitcnt = '0;
            c_d.oe     = 1'b0;
            c_d.wcnt   = '0;
            c_d.ridx   = '0;
        end else if (bus_stop) begin
            c_d.state = ST_IDLE;
            c_d.oe    = 1'b0;
        end else begin
            case (c_q.state)
                ST_ADDR, ST_RX: begin
                    if (scl_rise) begin
                        c_d.shift  = {c_q.shift[6:0], sda_s};
                        c_d.bitcnt = c_q.bitcnt + 4'd1;
                    end else if (scl_fall && c_q.bitcnt == 4'd8) begin
                        if (c_q.state == ST_ADDR) begin
                            if (c_q.shift[7:1] == DEV_ADDR) begin
                                c_d.state = ST_ADDR_ACK;
                                c_d.rw    = c_q.shift[0];
                                c_d.oe    = 1'b1;
                            end else begin
                                c_d.state = ST_WAIT;
                            end
                        end else begin
                            c_d.state = ST_RX_ACK;
                            c_d.oe    = 1'b1;
                            if (c_q.wcnt < WLIM) begin
                                c_d.wcnt = c_q.wcnt + CNT_W'(1);
                                if (c_q.wcnt >= CNT_W'(2)) begin
                                    wr_en   = 1'b1;
                                    wr_addr = c_q.wcnt - CNT_W'(2);
                                end
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        c_d.bitcnt = '0;
                        if (c_q.rw) begin
                            c_d.state = ST_TX;
                            c_d.shift = tx_byte;
                            c_d.ridx  = c_q.ridx + CNT_W'(1);
                            c_d.oe    = ~tx_byte[7];
                        end else begin
                            c_d.state = ST_RX;
                            c_d.oe    = 1'b0;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        c_d.state  = ST_RX;
                        c_d.bitcnt = '0;
                        c_d.oe     = 1'b0;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (c_q.bitcnt == 4'd7) begin
                            c_d.state = ST_TX_ACK;
                            c_d.oe    = 1'b0;
                        end else begin
                            c_d.shift  = {c_q.shift[6:0], 1'b0};
                            c_d.bitcnt = c_q.bitcnt + 4'd1;
                            c_d.oe     = ~c_q.shift[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        c_d.acked = ~sda_s;
                    end else if (scl_fall) begin
                        if (c_q.acked) begin
                            c_d.state  = ST_TX;
                            c_d.bitcnt = '0;
                            c_d.shift  = tx_byte;
                            c_d.oe     = ~tx_byte[7];
                            if (c_q.ridx < RLIM) c_d.ridx = c_q.ridx + CNT_W'(1);
                        end else begin
                            c_d.state = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{state: ST_IDLE, bitcnt: '0, shift: '0, rw: 1'b0,
                     acked: 1'b0, oe: 1'b0, wcnt: '0, ridx: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe_o = c_q.oe;

    cbs_reg_bank #(
        .NREGS    (NREGS),
        .AW       (CNT_W),
        .RST_VALS (RST_VALS),
        .RO_MASK  (RO_MASK)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (wr_en),
        .waddr_i  (wr_addr),
        .wdata_i  (c_q.shift),
        .status_i (status_i),
        .regs_o   (regs_o)
    );

    // Host-driven bits: the slave keeps SDA released.
    assert_host_bits_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_ADDR || c_q.state == ST_RX) |-> !sda_oe_o);
    // Acknowledge of an accepted data byte holds SDA low.
    assert_rx_ack_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_RX_ACK) |-> sda_oe_o);
    // After a NACK or a foreign address the slave stays off the bus.
    assert_wait_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_WAIT) |-> !sda_oe_o);
    // A register write is always followed by the acknowledge phase.
    assert_write_then_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (c_q.state == ST_RX_ACK));
    // The first byte of a read is the register count.
    assert_count_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_ADDR_ACK && c_q.rw && scl_fall && !bus_start && !bus_stop)
        |=> (c_q.shift == 8'(NREGS)));
    // SDA output changes only while SCL is low (synchronised view).
    assert_oe_on_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_rise || (!scl_fall && $past(scl_fall) == 1'b0 && c_q.state == ST_TX))
        |=> $stable(sda_oe_o));
endmodule

// File: tb/cfg_block_slave_test.sv
`timescale 1ns/1ps
module cfg_block_slave_test;
    localparam int Q = 10;
    localparam logic [55:0] DEF = 56'h00003FC77F4708;
    localparam logic [55:0] RO  = 56'h00000000008010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_scl = 1'b1;
    logic host_sda = 1'b1;
    logic sda_oe;
    logic [55:0] status = '1;
    logic [55:0] regs;
    wire sda_line = host_sda & ~sda_oe;

    int checks = 0;
    int fails  = 0;
    logic [55:0] mdl = DEF;
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];

    always #2.5 clk = ~clk;

    cfg_block_slave uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (host_scl),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .status_i (status),
        .regs_o   (regs)
    );

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(logic ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [55:0] exp_regs();
        return (mdl & ~RO) | (status & RO);
    endfunction

    task automatic bus_start();
        host_sda = 1'b1; tick(Q); host_scl = 1'b1; tick(Q);
        host_sda = 1'b0; tick(Q); host_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; tick(Q); host_scl = 1'b1; tick(Q);
        host_sda = 1'b1; tick(2*Q);
    endtask

    // Sends a byte, returns the acknowledge and whether the slave drove during data bits.
    task automatic put_byte(logic [7:0] b, output logic ack, output logic drove);
        drove = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i]; tick(Q);
            host_scl = 1'b1; tick(Q);
            if (sda_oe) drove = 1'b1;
            host_scl = 1'b0; tick(Q);
        end
        host_sda = 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
        ack = ~sda_line;
        host_scl = 1'b0; tick(Q);
    endtask

    task automatic get_byte(logic give_ack, output logic [7:0] b);
        host_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(Q); host_scl = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            host_scl = 1'b0;
        end
        tick(Q);
        host_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        host_scl = 1'b1; tick(Q);
        host_scl = 1'b0; tick(Q);
        host_sda = 1'b1;
    endtask

    // Write: address, two dummies, then data; model follows R2/R3/R9.
    task automatic write_block(logic [7:0] data [], string req);
        logic a, d;
        put_byte(8'hD2, a, d);
        check(a === 1'b1, "R1 write address ack", {63'd0, a}, 64'd1);
        put_byte(8'h3C, a, d);
        check(a === 1'b1 && !d, "R2 dummy command ack", {63'd0, a}, 64'd1);
        put_byte(8'hC3, a, d);
        check(a === 1'b1 && !d, "R2 dummy count ack", {63'd0, a}, 64'd1);
        check(regs === exp_regs(), "R2 dummies ignored", {8'd0, regs}, {8'd0, exp_regs()});
        foreach (data[i]) begin
            put_byte(data[i], a, d);
            check(a === 1'b1, req, {63'd0, a}, 64'd1);
            check(!d, "R10 released during host bits", {63'd0, d}, 64'd0);
            if (i < 7) mdl[i*8 +: 8] = data[i];
        end
    endtask

    task automatic read_block(int n_ack);
        logic a, d;
        logic [7:0] b;
        put_byte(8'hD3, a, d);
        check(a === 1'b1, "R1 read address ack", {63'd0, a}, 64'd1);
        exp_q.push_back(8'd7);
        for (int k = 0; k < 7; k++) exp_q.push_back(exp_regs()[k*8 +: 8]);
        for (int k = 0; k <= n_ack; k++) begin
            get_byte(k < n_ack, b);
            got_q.push_back(b);
        end
    endtask

    // Monitor: compares each received read byte against the expected queue.
    initial begin
        forever begin
            @(negedge clk);
            if (got_q.size() != 0) begin
                logic [7:0] g, e;
                g = got_q.pop_front();
                e = (exp_q.size() != 0) ? exp_q.pop_front() : 8'hFF;
                check(g === e, "R5 read byte", {56'd0, g}, {56'd0, e});
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic a, d, stuck;
        logic [7:0] full [] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'hA5, 8'h5A};
        logic [7:0] part [] = '{8'hE1, 8'hE2, 8'hE3};
        tick(5);
        rst_n = 1'b1;
        tick(5);
        check(regs === exp_regs(), "R6 reset values", {8'd0, regs}, {8'd0, exp_regs()});
        check(sda_oe === 1'b0, "R6 bus released after reset", {63'd0, sda_oe}, 64'd0);

        // Foreign address is ignored.
        bus_start();
        put_byte(8'hA0, a, d);
        check(a === 1'b0, "R1 foreign address not acked", {63'd0, a}, 64'd0);
        put_byte(8'hFF, a, d);
        check(a === 1'b0 && !d, "R1 silent after foreign address", {63'd0, a}, 64'd0);
        bus_stop();
        check(regs === exp_regs(), "R1 bank unchanged", {8'd0, regs}, {8'd0, exp_regs()});

        // Full write with two surplus bytes.
        bus_start();
        write_block(full, "R9 data and surplus bytes acked");
        bus_stop();
        check(regs === exp_regs(), "R3 ascending load, R7 and R9", {8'd0, regs}, {8'd0, exp_regs()});

        // Short write stopped after three bytes.
        bus_start();
        write_block(part, "R3 short write ack");
        bus_stop();
        check(regs === exp_regs(), "R4 unreached registers kept", {8'd0, regs}, {8'd0, exp_regs()});

        // Read all eight bytes, NACK the last.
        bus_start();
        read_block(7);
        stuck = 1'b0;
        for (int i = 0; i < 9; i++) begin
            tick(Q); host_scl = 1'b1; tick(Q);
            if (sda_line !== 1'b1) stuck = 1'b1;
            host_scl = 1'b0;
        end
        tick(Q);
        check(!stuck, "R8 released after NACK", {63'd0, stuck}, 64'd0);
        bus_stop();

        // Read-only bits follow status; a write cannot change them.
        status = '0;
        tick(2);
        check(regs === exp_regs(), "R7 read-only follows status", {8'd0, regs}, {8'd0, exp_regs()});
        bus_start();
        write_block('{8'hFF, 8'hFF}, "R7 write to read-only ack");
        bus_stop();
        check(regs[4] === 1'b0 && regs[15] === 1'b0, "R7 read-only not written",
              {62'd0, regs[15], regs[4]}, 64'd0);
        bus_start();
        read_block(7);
        bus_stop();

        tick(20);
        check(exp_q.size() == 0, "R5 all read bytes seen", 64'(exp_q.size()), 64'd0);
        summary();
    end
endmodule